// File: doc/BRIEF.md
# Road Stream Merger and Event Formatter

This block collects matched-road words from several input streams, each coming from one daughter board, and merges them into a single output stream for the downstream processor. Every input carries a series of road words for one event, closed by an end-of-event word. The merger forwards road words from all inputs as they arrive. Once every input has closed the current event, it emits one combined end-of-event word. When it has nothing to forward, it fills the output with its own idle word.

Each input is a 32-bit word with a 4-bit control-character mask and a valid/ready handshake. The output is a registered 32-bit word with its mask. A new word is loaded on every clock edge at which `out_ready` is high, so the output always carries a road, an end-of-event or an idle word. An input that has closed its event is held off until the combined end-of-event word has gone out. This keeps roads of the next event behind the marker of the current one.

Top module: `road_merge`

## Requirements
- R1: After reset the output holds the idle word 0x0000BC50 with mask 4'b0010, and no input is counted as closed.
- R2: An input word with mask 4'b0000 is a road (hit bitmap in bits 31:24, road address in bits 23:0). It appears unmodified on the output with mask 4'b0000 after the clock edge at which it is accepted, and roads from one input leave in the order they arrived.
- R3: At most one road is accepted per clock. Inputs holding a road are served round-robin, starting after the input served last. After reset, input 0 is served first.
- R4: An input word with mask 4'b1000 and top byte 0xF7 closes that input's event. Its bits 23:16 are an error byte and bits 15:0 an event identifier. It is accepted whether or not `out_ready` is high.
- R5: A closed input keeps its `in_ready` low until the combined end-of-event word has been loaded onto the output.
- R6: When all inputs are closed and `out_ready` is high, the next edge loads the combined end-of-event word (mask 4'b1000, top byte 0xF7) and reopens all inputs. No road of an event leaves after that event's combined word.
- R7: The combined word carries, in bits 15:0, the identifier from input 0. Its bits 23:16 hold the bitwise OR of all inputs' error bytes, with bit 23 also set when any input's identifier differs from input 0's.
- R8: Input words that are neither roads nor valid end-of-event words are consumed and dropped. This covers the input idle word 0xBCBC1C1C with mask 4'b1111, other masks, and mask 4'b1000 with a top byte other than 0xF7.
- R9: On an edge with `out_ready` high, no road accepted and not all inputs closed, the output idle word 0x0000BC50 with mask 4'b0010 is loaded. Only the masks 4'b0000, 4'b0010 and 4'b1000 ever appear on the output.
- R10: While `out_ready` is low, the output word and mask hold and no road is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32*N_IN | Input words, input k in bits 32k+31:32k |
| in_ctl | input | 4*N_IN | Control-character masks, input k in bits 4k+3:4k |
| in_valid | input | N_IN | Word present on input k |
| in_ready | output | N_IN | Input k word taken this clock |
| out_data | output | 32 | Merged output word |
| out_ctl | output | 4 | Control-character mask of the output word |
| out_ready | input | 1 | Downstream takes the output word at this edge |

## Verification
Road forwarding and end-of-event capture can fall in the same clock. One input presents its closing word while other inputs are still being granted roads, and the last input to close can do so while `out_ready` is low. The bench provokes this with inputs of unequal road counts, interleaved idle and junk words, and random valid and ready patterns. It judges each output word against per-input road queues and a precomputed combined word, and checks that no road of an event trails that event's combined word.

// File: rtl/road_merge.sv
module road_merge #(
  parameter int N_IN = 4,
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [32*N_IN-1:0]  in_data,
  input  logic [4*N_IN-1:0]   in_ctl,
  input  logic [N_IN-1:0]     in_valid,
  output logic [N_IN-1:0]     in_ready,
  output logic [31:0]         out_data,
  output logic [3:0]          out_ctl,
  input  logic                out_ready
);
  localparam logic [31:0] IDLE_W = 32'h0000BC50;
  localparam logic [3:0]  IDLE_C = 4'b0010;
  localparam logic [3:0]  EOE_C  = 4'b1000;
  localparam logic [7:0]  EOE_K  = 8'hF7;

  logic [31:0]     w [N_IN];
  logic [3:0]      c [N_IN];
  logic [15:0]     id_q [N_IN];
  logic [N_IN-1:0] done_q, is_road, is_eoe, grant, road_take;
  logic [7:0]      err_q;
  logic [IW-1:0]   ptr_q, gidx;
  logic            mism;

  wire close_all = &done_q;

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      w[i] = in_data[32*i +: 32];
      c[i] = in_ctl[4*i +: 4];
      is_road[i] = in_valid[i] && !done_q[i] && (c[i] == 4'b0000);
      is_eoe[i]  = in_valid[i] && !done_q[i] && (c[i] == EOE_C) && (w[i][31:24] == EOE_K);
    end
  end

  always_comb begin
    grant = '0;
    gidx  = ptr_q;
    for (int k = 1; k <= N_IN; k++) begin
      int j;
      j = (int'(ptr_q) + k) % N_IN;
      if (grant == '0 && is_road[j]) begin
        grant[j] = 1'b1;
        gidx = IW'(j);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_IN; i++)
      in_ready[i] = !done_q[i] && ((c[i] != 4'b0000) || (grant[i] && out_ready));
  end

  assign road_take = is_road & in_ready;

  always_comb begin
    mism = 1'b0;
    for (int i = 1; i < N_IN; i++)
      if (id_q[i] != id_q[0]) mism = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data <= IDLE_W;
      out_ctl  <= IDLE_C;
      done_q   <= '0;
      err_q    <= '0;
      ptr_q    <= IW'(N_IN - 1);
      for (int i = 0; i < N_IN; i++) id_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_IN; i++) begin
        if (is_eoe[i]) begin
          done_q[i] <= 1'b1;
          id_q[i]   <= w[i][15:0];
        end
      end
      if (|is_eoe) begin
        logic [7:0] acc;
        acc = err_q;
        for (int i = 0; i < N_IN; i++)
          if (is_eoe[i]) acc = acc | w[i][23:16];
        err_q <= acc;
      end
      if (out_ready) begin
        if (close_all) begin
          out_data <= {EOE_K, err_q | {mism, 7'b0}, id_q[0]};
          out_ctl  <= EOE_C;
          done_q   <= '0;
          err_q    <= '0;
        end else if (|grant) begin
          out_data <= w[gidx];
          out_ctl  <= 4'b0000;
          ptr_q    <= gidx;
        end else begin
          out_data <= IDLE_W;
          out_ctl  <= IDLE_C;
        end
      end
    end
  end

  assert_one_road_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(road_take));

  assert_road_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && |road_take) |=> (out_ctl == 4'b0000));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |=> ($stable(out_data) && $stable(out_ctl)));

  assert_no_road_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> (road_take == '0));

  assert_eoe_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && close_all) |=> (out_ctl == EOE_C && out_data[31:24] == EOE_K && done_q == '0));

  assert_idle_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !close_all && road_take == '0) |=> (out_data == IDLE_W && out_ctl == IDLE_C));

  assert_ctl_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ctl == 4'b0000 || out_ctl == IDLE_C || out_ctl == EOE_C));

endmodule

// File: tb/road_merge_tb.sv
module road_merge_tb;
  localparam int N = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [32*N-1:0] in_data = '0;
  logic [4*N-1:0]  in_ctl = '0;
  logic [N-1:0]    in_valid = '0;
  logic [N-1:0]    in_ready;
  logic [31:0]     out_data;
  logic [3:0]      out_ctl;
  logic            out_ready = 1'b0;

  road_merge #(.N_IN(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_ctl(in_ctl),
    .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
    .out_ctl(out_ctl), .out_ready(out_ready));

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  logic [35:0] src_q [N][$];
  logic [31:0] exp_q [N][$];
  logic [31:0] eoe_q [$];
  logic [N-1:0] closed = '0;
  logic [31:0] prev_d;
  logic [3:0]  prev_c;
  logic        log_on = 1'b0;
  int          rr_log [$];

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] eoe_word(input logic [15:0] ev, input logic [31:0] errs, input logic [63:0] ids);
    logic [7:0] e;
    logic m;
    e = '0; m = 1'b0;
    for (int i = 0; i < N; i++) begin
      e = e | errs[8*i +: 8];
      if (ids[16*i +: 16] != ids[15:0]) m = 1'b1;
    end
    return {8'hF7, e | {m, 7'b0}, ids[15:0]};
  endfunction

  task automatic make_event(input logic [15:0] ev, input int max_roads, input bit noise,
                            input logic [31:0] errs, input logic [63:0] ids);
    for (int i = 0; i < N; i++) begin
      int nr = (max_roads < 0) ? -max_roads : $urandom_range(0, max_roads);
      for (int r = 0; r < nr; r++) begin
        logic [31:0] road;
        road = {8'($urandom), 2'(i), ev[7:0], 14'(r)};
        if (noise && $urandom_range(0, 3) == 0) src_q[i].push_back({4'b1111, 32'hBCBC1C1C});
        if (noise && $urandom_range(0, 7) == 0) src_q[i].push_back({4'b0100, 32'($urandom)});
        if (noise && $urandom_range(0, 7) == 0) src_q[i].push_back({4'b1000, 8'h3C, 24'($urandom)});
        src_q[i].push_back({4'b0000, road});
        exp_q[i].push_back(road);
      end
      src_q[i].push_back({4'b1000, 8'hF7, errs[8*i +: 8], ids[16*i +: 16]});
    end
    eoe_q.push_back(eoe_word(ev, errs, ids));
  endtask

  task automatic check_out();
    if (!out_ready) begin
      chk(out_data == prev_d && out_ctl == prev_c, "R10 hold", {out_ctl, out_data}, {prev_c, prev_d});
    end else if (out_ctl == 4'b0000) begin
      int s = int'(out_data[23:22]);
      if (log_on) rr_log.push_back(s);
      if (exp_q[s].size() == 0) chk(1'b0, "R2 unexpected road", {4'b0, out_data}, 36'h0);
      else begin
        logic [31:0] e = exp_q[s].pop_front();
        chk(out_data == e, "R2 road passthrough", {4'b0, out_data}, {4'b0, e});
      end
    end else if (out_ctl == 4'b1000) begin
      logic [31:0] e = (eoe_q.size() > 0) ? eoe_q.pop_front() : 32'hDEAD_BEEF;
      chk(out_data == e, "R7 combined end-of-event", {out_ctl, out_data}, {4'b1000, e});
      for (int i = 0; i < N; i++)
        if (exp_q[i].size() > 0)
          chk(exp_q[i][0][21:14] != out_data[7:0], "R6 road behind marker",
              {4'b0, exp_q[i][0]}, {4'b0, out_data});
      closed = '0;
    end else begin
      chk(out_ctl == 4'b0010 && out_data == 32'h0000BC50, "R9 idle/R8 dropped word",
          {out_ctl, out_data}, {4'b0010, 32'h0000BC50});
    end
    prev_d = out_data;
    prev_c = out_ctl;
  endtask

  function automatic bit all_empty();
    for (int i = 0; i < N; i++) if (src_q[i].size() != 0 || exp_q[i].size() != 0) return 1'b0;
    return eoe_q.size() == 0;
  endfunction

  task automatic run(input int vprob, input int rprob, input int limit);
    int cyc = 0;
    while (!all_empty() && cyc < limit) begin
      @(negedge clk);
      check_out();
      out_ready = ($urandom_range(0, 99) < rprob);
      for (int i = 0; i < N; i++) begin
        if (src_q[i].size() > 0 && $urandom_range(0, 99) < vprob) begin
          in_valid[i] = 1'b1;
          {in_ctl[4*i +: 4], in_data[32*i +: 32]} = src_q[i][0];
        end else begin
          in_valid[i] = 1'b0;
          in_data[32*i +: 32] = 32'($urandom);
          in_ctl[4*i +: 4] = 4'($urandom);
        end
      end
      #8;
      for (int i = 0; i < N; i++) begin
        if (closed[i] && in_valid[i])
          chk(in_ready[i] == 1'b0, "R5 closed input held", {35'b0, in_ready[i]}, 36'h0);
        if (in_valid[i] && in_ready[i]) begin
          logic [35:0] wd = src_q[i].pop_front();
          if (wd[35:32] == 4'b1000 && wd[31:24] == 8'hF7) closed[i] = 1'b1;
        end
      end
      cyc++;
    end
    if (cyc >= limit) chk(1'b0, "run limit", 36'(cyc), 36'(limit));
    @(negedge clk);
    check_out();
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_data == 32'h0000BC50 && out_ctl == 4'b0010, "R1 reset idle",
        {out_ctl, out_data}, {4'b0010, 32'h0000BC50});
    prev_d = out_data; prev_c = out_ctl;

    // R3 round-robin order, R4 close while roads still flow
    make_event(16'h0001, -2, 1'b0, 32'h0, {4{16'h0001}});
    log_on = 1'b1;
    run(100, 100, 200);
    log_on = 1'b0;
    chk(rr_log.size() == 8, "R3 road count", 36'(rr_log.size()), 36'd8);
    for (int k = 0; k < 8 && k < rr_log.size(); k++)
      chk(rr_log[k] == (k % N), "R3 round-robin order", 36'(rr_log[k]), 36'(k % N));

    // R7 error OR and identifier mismatch
    make_event(16'h0002, 2, 1'b1, 32'h08040201, {4{16'h0002}});
    make_event(16'h0003, 2, 1'b1, 32'h00000010, {16'h0003, 16'h0103, 16'h0003, 16'h0003});
    run(80, 100, 400);

    // R4 closing under stalled output, R10 hold, R8 noise
    make_event(16'h0004, 3, 1'b1, 32'h00200000, {4{16'h0004}});
    run(100, 20, 1000);

    // random mix
    for (int ev = 5; ev < 205; ev++) begin
      logic [31:0] errs = 0;
      logic [63:0] ids = {4{16'(ev)}};
      if ($urandom_range(0, 3) == 0) errs = 32'($urandom) & 32'h7F7F7F7F;
      if ($urandom_range(0, 5) == 0) ids[16*$urandom_range(1, N-1) +: 16] = 16'($urandom);
      make_event(16'(ev), 5, 1'b1, errs, ids);
      run($urandom_range(30, 100), $urandom_range(30, 100), 2000);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule